// File: doc/BRIEF.md
# Mixed-Bit Weight Unpacking Front End

This block is the decode stage that sits in front of a shared integer multiply-accumulate back end. Quantized weights arrive in packed form, with each weight split into a low bit field and a high bit field that are stored in two separate words. The block joins the two fields of every weight and removes the format's bias. It then delivers a vector of signed 8-bit weights, so the back end works the same way whichever format was stored.

Two formats are supported and one input selects between them. The wide format joins a 4-bit low field with a 2-bit high field into a signed value in the range -32..31. The narrow format joins a 2-bit low field with a 1-bit high field into a signed value in the range -4..3, which is then sign-extended to 8 bits. Packed words come in on a valid/ready stream and one vector of decoded weights leaves per accepted beat, one cycle later. The stream runs at one beat per cycle while the consumer is ready.

Top module: `wunp_front`

## Requirements
- R1: With format 0 (wide), lane i's output is ({in_hi[2i+1:2i], in_lo[4i+3:4i]}) minus 32, as an 8-bit two's-complement value in the range -32..31.
- R2: With format 1 (narrow), lane i's output is ({in_hi[i], in_lo[2i+1:2i]}) minus 4, sign-extended to 8 bits. In this format in_lo[31:16] and in_hi[15:8] have no effect on the output.
- R3: Lane i of a beat appears at out_data[8i+7:8i], so lanes rise in index from the least significant byte.
- R4: in_fmt is encoded 0 = wide and 1 = narrow. out_fmt reports the format that was used to decode the beat currently on out_data.
- R5: The format is taken from in_fmt only when the output stage is empty. A beat accepted while the output stage holds a beat is decoded with the held format, and changes on in_fmt are ignored until the stage empties.
- R6: A beat accepted at a clock edge is presented with out_valid high directly after that edge (latency of one cycle).
- R7: in_ready is high whenever the output stage is empty or out_ready is high, so that with out_ready held high one beat is accepted every cycle.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_fmt hold their values.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packed beat is offered |
| in_ready | output | 1 | The block can take the offered beat |
| in_fmt | input | 1 | Format select: 0 wide, 1 narrow |
| in_lo | input | 32 | Packed low fields of 8 weights |
| in_hi | input | 16 | Packed high fields of 8 weights |
| out_valid | output | 1 | A decoded vector is presented |
| out_ready | input | 1 | The consumer takes the vector |
| out_data | output | 64 | Eight signed 8-bit decoded weights |
| out_fmt | output | 1 | Format used for the presented vector |

## Verification
The assertions assume that the consumer follows the usual stream rules and that the producer holds in_valid and its data until in_ready takes them. They also assume that in_fmt is a clean 0 or 1 at every edge. The stimulus holds each beat until it is accepted and never withdraws one. The packed words sweep every value of each field in every lane, in both formats. The format input is toggled only at chosen points: once while a beat is held in the output stage, to exercise the ignore rule, and otherwise at an empty pipeline. Consumer readiness runs both always-on and in a repeating stall pattern, so the hold and throughput rules are exercised under the same field sweeps.

// File: rtl/wunp_pkg.sv
package wunp_pkg;

  // Geometry of the two packed formats
  localparam int LANES_DEF = 8;
  localparam int WLO_W     = 4;   // wide format, low field
  localparam int WHI_W     = 2;   // wide format, high field
  localparam int NLO_W     = 2;   // narrow format, low field
  localparam int NHI_W     = 1;   // narrow format, high field
  localparam int OUT_W     = 8;   // back-end operand width

  localparam int WRAW_W    = WLO_W + WHI_W;
  localparam int NRAW_W    = NLO_W + NHI_W;
  localparam int WBIAS     = 1 << (WRAW_W - 1);
  localparam int NBIAS     = 1 << (NRAW_W - 1);

  typedef enum logic {
    FMT_WIDE   = 1'b0,
    FMT_NARROW = 1'b1
  } fmt_e;

  // Join fields and remove the bias of the wide format
  function automatic logic [OUT_W-1:0] join_wide(
    input logic [WLO_W-1:0] lo,
    input logic [WHI_W-1:0] hi
  );
    logic [OUT_W-1:0] raw;
    raw = OUT_W'({hi, lo});
    return raw - OUT_W'(WBIAS);
  endfunction

  // Join fields, remove the bias in the narrow width, then sign-extend
  function automatic logic [OUT_W-1:0] join_narrow(
    input logic [NLO_W-1:0] lo,
    input logic [NHI_W-1:0] hi
  );
    logic [NRAW_W-1:0] n;
    n = {hi, lo} - NRAW_W'(NBIAS);
    return {{(OUT_W-NRAW_W){n[NRAW_W-1]}}, n};
  endfunction

endpackage

// File: rtl/wunp_lane.sv
module wunp_lane
  import wunp_pkg::*;
(
  input  logic [WLO_W-1:0] wlo,
  input  logic [WHI_W-1:0] whi,
  input  logic [NLO_W-1:0] nlo,
  input  logic [NHI_W-1:0] nhi,
  input  fmt_e             fmt,
  output logic [OUT_W-1:0] weight
);

  logic [OUT_W-1:0] wide_val;
  logic [OUT_W-1:0] narrow_val;

  assign wide_val   = join_wide(wlo, whi);
  assign narrow_val = join_narrow(nlo, nhi);

  always_comb begin
    unique case (fmt)
      FMT_NARROW: weight = narrow_val;
      default:    weight = wide_val;
    endcase
  end

endmodule

// File: rtl/wunp_fmt_track.sv
module wunp_fmt_track
  import wunp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  fmt_e fmt_in,
  input  logic stage_full,
  input  logic accept,
  output fmt_e fmt_use
);

  fmt_e fmt_held;

  // Outside format only while nothing is held downstream
  assign fmt_use = stage_full ? fmt_held : fmt_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_held <= FMT_WIDE;
    end else if (accept) begin
      fmt_held <= fmt_use;
    end
  end

endmodule

// File: rtl/wunp_out_stage.sv
module wunp_out_stage
  import wunp_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] d_in,
  input  fmt_e          fmt_in,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output fmt_e          out_fmt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_fmt   <= FMT_WIDE;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= d_in;
        out_fmt   <= fmt_in;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wunp_front.sv
module wunp_front
  import wunp_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  localparam int LO_W = LANES * WLO_W,
  localparam int HI_W = LANES * WHI_W,
  localparam int DW   = LANES * OUT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_fmt,
  input  logic [LO_W-1:0] in_lo,
  input  logic [HI_W-1:0] in_hi,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data,
  output logic            out_fmt
);

  // Named internal events (observed by the bound checker)
  logic          accept;
  logic          stage_full;
  fmt_e          fmt_use;
  fmt_e          fmt_out_e;
  logic [DW-1:0] decoded;

  assign stage_full = out_valid;
  assign in_ready   = !stage_full || out_ready;
  assign accept     = in_valid && in_ready;

  wunp_fmt_track u_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_in     (fmt_e'(in_fmt)),
    .stage_full (stage_full),
    .accept     (accept),
    .fmt_use    (fmt_use)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wunp_lane u_lane (
      .wlo    (in_lo[i*WLO_W +: WLO_W]),
      .whi    (in_hi[i*WHI_W +: WHI_W]),
      .nlo    (in_lo[i*NLO_W +: NLO_W]),
      .nhi    (in_hi[i*NHI_W +: NHI_W]),
      .fmt    (fmt_use),
      .weight (decoded[i*OUT_W +: OUT_W])
    );
  end

  wunp_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .d_in      (decoded),
    .fmt_in    (fmt_use),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_fmt   (fmt_out_e)
  );

  assign out_fmt = fmt_out_e;

endmodule

// File: rtl/wunp_front_chk.sv
module wunp_front_chk
  import wunp_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  localparam int DW   = LANES * OUT_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_fmt,
  input logic          accept
);

  localparam int NEXT = OUT_W - NRAW_W + 1;   // equal top bits, narrow
  localparam int WEXT = OUT_W - WRAW_W + 1;   // equal top bits, wide

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R6

  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fmt))); // R8

  AST_FMT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && accept) |=> (out_fmt == $past(out_fmt))); // R5

  for (genvar i = 0; i < LANES; i++) begin : g_rng
    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fmt) |->
        ($countones(out_data[i*OUT_W+NRAW_W-1 +: NEXT]) inside {0, NEXT})); // R2
    AST_WIDE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_fmt) |->
        ($countones(out_data[i*OUT_W+WRAW_W-1 +: WEXT]) inside {0, WEXT})); // R1
  end

endmodule

bind wunp_front wunp_front_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_fmt   (out_fmt),
  .accept    (accept)
);

// File: tb/sim_wunp_front.sv
`timescale 1ns/1ps
module sim_wunp_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_fmt = 1'b0;
  logic [31:0] in_lo = '0;
  logic [15:0] in_hi = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic        out_fmt;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  int stall_pat = 0;

  logic [64:0] expq[$];
  logic        last_fmt = 1'b0;
  logic        prev_stall = 1'b0;
  logic [63:0] prev_data = '0;
  logic        prev_fmt = 1'b0;
  logic        prev_push = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  wunp_front u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_lo(in_lo), .in_hi(in_hi), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_fmt(out_fmt)
  );

  // Bench model: arithmetic on integers per lane
  function automatic logic [63:0] model(logic [31:0] lo, logic [15:0] hi, logic f);
    logic [63:0] e;
    for (int l = 0; l < 8; l++) begin
      int v;
      if (!f) v = int'(hi[2*l +: 2]) * 16 + int'(lo[4*l +: 4]) - 32;
      else    v = int'(hi[l]) * 4 + int'(lo[2*l +: 2]) - 4;
      e[8*l +: 8] = v[7:0];
    end
    return e;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] lo, input logic [15:0] hi,
                      input logic f, input logic r, output logic took);
    logic was_empty;
    logic fuse;
    logic [64:0] e;
    @(negedge clk);
    in_valid = v; in_lo = lo; in_hi = hi; in_fmt = f; out_ready = r;
    #1;
    cyc++;
    if (prev_stall) begin
      chk(out_valid && out_data == prev_data && out_fmt == prev_fmt,
          "R8 stall hold", out_data, prev_data);
    end
    if (prev_push) chk(out_valid, "R6 latency", 64'(out_valid), 64'd1);
    chk(out_valid == (expq.size() != 0), "R6 occupancy", 64'(out_valid), 64'(expq.size() != 0));
    chk(in_ready == (!out_valid || r), "R7 ready", 64'(in_ready), 64'(!out_valid || r));
    was_empty = (expq.size() == 0);
    if (out_valid && r && !was_empty) begin
      e = expq.pop_front();
      chk(out_data == e[63:0], e[64] ? "R2/R3 narrow data" : "R1/R3 wide data",
          out_data, e[63:0]);
      chk(out_fmt == e[64], "R4/R5 format", 64'(out_fmt), 64'(e[64]));
    end
    took = v && in_ready;
    if (took) begin
      fuse = was_empty ? f : last_fmt;
      last_fmt = fuse;
      expq.push_back({fuse, model(lo, hi, fuse)});
    end
    prev_stall = out_valid && !r;
    prev_data  = out_data;
    prev_fmt   = out_fmt;
    prev_push  = took;
  endtask

  function automatic logic rdy_now();
    if (stall_pat == 0) return 1'b1;
    return (cyc % 3) != 1;
  endfunction

  task automatic send(logic [31:0] lo, logic [15:0] hi, logic f);
    logic took;
    took = 1'b0;
    while (!took) step(1'b1, lo, hi, f, rdy_now(), took);
  endtask

  task automatic drain();
    logic took;
    for (int k = 0; k < 3; k++) step(1'b0, '0, '0, last_fmt, 1'b1, took);
  endtask

  // R1: all 64 field values per lane, wide format
  task automatic sweep_wide();
    for (int v = 0; v < 64; v++) begin
      logic [31:0] lo;
      logic [15:0] hi;
      for (int l = 0; l < 8; l++) begin
        int val;
        val = (v + 9 * l) % 64;
        lo[4*l +: 4] = 4'(val % 16);
        hi[2*l +: 2] = 2'(val / 16);
      end
      send(lo, hi, 1'b0);
    end
  endtask

  // R2: all 8 field values per lane, narrow format, unused bits filled
  task automatic sweep_narrow();
    for (int v = 0; v < 8; v++) begin
      logic [31:0] lo;
      logic [15:0] hi;
      lo = {16'hC3A5 ^ 16'(v * 4369), 16'h0};
      hi = {8'h5A + 8'(v * 37), 8'h0};
      for (int l = 0; l < 8; l++) begin
        int val;
        val = (v + 3 * l) % 8;
        lo[2*l +: 2] = 2'(val % 4);
        hi[l]        = 1'(val / 4);
      end
      send(lo, hi, 1'b1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic took;
    int c0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R9 reset out_valid", 64'(out_valid), 64'd0);
    chk(in_ready, "R9 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // R7 full throughput with a ready consumer
    stall_pat = 0;
    c0 = cyc;
    sweep_wide();
    chk(cyc - c0 == 64, "R7 throughput", 64'(cyc - c0), 64'd64);
    drain();
    sweep_narrow();
    drain();

    // Stalling consumer, both formats (R8)
    stall_pat = 1;
    sweep_wide();
    drain();
    sweep_narrow();
    drain();

    // R5: format change while a beat is held is ignored
    step(1'b1, 32'h1234_5678, 16'h9ABC, 1'b0, 1'b0, took);   // A, wide, stage empty
    step(1'b1, 32'hFEDC_BA98, 16'h7654, 1'b1, 1'b0, took);   // stalled, not taken
    step(1'b1, 32'hFEDC_BA98, 16'h7654, 1'b1, 1'b1, took);   // B taken with held wide
    chk(took, "R5 beat taken while held", 64'(took), 64'd1);
    step(1'b0, '0, '0, 1'b1, 1'b0, took);
    chk(out_fmt == 1'b0, "R5 held format", 64'(out_fmt), 64'd0);
    drain();
    step(1'b1, 32'hFEDC_BA98, 16'h7654, 1'b1, 1'b1, took);   // C at empty: narrow
    step(1'b0, '0, '0, 1'b1, 1'b0, took);
    chk(out_fmt == 1'b1, "R5 format at empty", 64'(out_fmt), 64'd1);
    drain();
    chk(expq.size() == 0, "R6 all beats delivered", 64'(expq.size()), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule